// File: doc/BRIEF.md
# Cache ECC error trap controller

This block decides which processor trap, if any, an ECC or system-bus error should raise, and keeps a sticky record of every error class it has seen. Each event port delivers a one-cycle strobe that carries an error class, the access type that hit the error, and a subtype used only for interrupt-vector fetches. The block combines these with three trap-enable bits in a control register. The result drives four trap request lines: fast ECC, instruction access, data access and disrupting ECC. The enable bits gate only the trap requests. The status flags always record the event.

The same control register also carries fault-injection fields. When a force bit is set, a programmed check value replaces the check bits that the ECC generator produces, one field for data and one for the tag. Software reaches both registers through a small CSR port. Address 0 selects the control register and address 1 selects the status flags. Reads are combinational.

Top module: `ecc_trap_ctrl`

## Requirements
- R1: After reset the control register and the status flags read as zero. At address 0, bit 2 and bits 31:19 always read as zero, whatever is written to them. All other control bits read back what was written.
- R2: Error class 0 (software-correctable cache error) and error class 1 (uncorrectable cache error) raise the fast ECC trap when control bit 3 is set and the access is a local read. The local read access codes are 0 (fetch), 1 (load) and 2 (atomic).
- R3: Classes 0 and 1 never raise the fast ECC trap on access 3 (merge), 4 (writeback), 5 (copyout) or 6 (vector fetch).
- R4: Classes 2 (uncorrectable bus data), 3 (uncorrectable tag), 4 (bus timeout) and 5 (bus error) are routed only when control bit 1 is set. Access 0 raises the instruction access trap. Accesses 1 and 2 raise the data access trap. Accesses 3, 4 and 5 raise the disrupting trap.
- R5: When a class 2 to 5 error occurs on access 6 (vector fetch), the 2-bit subtype selects the trap. Subtype 0 raises instruction access, 1 raises data access, 2 raises disrupting, and 3 raises nothing.
- R6: Classes 6 (corrected data) and 7 (corrected tag) raise the disrupting trap on any access code from 0 to 6, when control bit 0 is set.
- R7: Every valid event sets status bit N, where N is its class code, whatever the enables are.
- R8: Writing 1 to a status bit at address 1 clears that bit. Writing 0 leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R9: A trap request is registered. It is asserted for exactly the one cycle after the event's cycle. Requests from events on different ports in the same cycle are asserted together.
- R10: With control bit 13 set, the data check output equals control bits 12:4. Otherwise it equals the generated data check input. With bit 18 set, the tag check output equals bits 17:14. Otherwise it equals the generated tag check input. The two force strobe outputs mirror bits 13 and 18, and the data and tag forces act independently.
- R11: Access code 7 is reserved. It raises no trap for any class, but the event is still logged as R7 requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | NUM_PORTS | Error event strobe, one per port |
| evt_cls_i | input | 3*NUM_PORTS | Error class per port |
| evt_acc_i | input | 3*NUM_PORTS | Access type per port |
| evt_vsub_i | input | 2*NUM_PORTS | Vector-fetch trap subtype per port |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 1 | CSR select: 0 control, 1 status |
| csr_wdata_i | input | DATA_W | CSR write data |
| csr_rdata_o | output | DATA_W | CSR read data |
| gen_data_chk_i | input | 9 | Generated data check bits |
| gen_tag_chk_i | input | 4 | Generated tag check bits |
| data_chk_o | output | 9 | Data check bits after the force mux |
| tag_chk_o | output | 4 | Tag check bits after the force mux |
| force_data_o | output | 1 | Data check force strobe |
| force_tag_o | output | 1 | Tag check force strobe |
| trap_fast_o | output | 1 | Fast ECC trap request |
| trap_iacc_o | output | 1 | Instruction access trap request |
| trap_dacc_o | output | 1 | Data access trap request |
| trap_disr_o | output | 1 | Disrupting ECC trap request |

## Verification
The hardest case to reach is a status bit that is set by an event and cleared by software in the same cycle, because it needs a CSR write and an event strobe to line up on one edge. The bench drives both in the same cycle, once with a clear of all bits while one port reports a class, and then checks that only that class's bit survives. The same alignment problem arises when two ports report in one cycle and each asks for a different trap. The bench covers it with paired events whose trap requests must appear together on the same cycle.

// File: rtl/ecc_trap_pkg.sv
package ecc_trap_pkg;
  localparam int unsigned CLS_W   = 3;
  localparam int unsigned ACC_W   = 3;
  localparam int unsigned VSUB_W  = 2;
  localparam int unsigned NUM_CLS = 1 << CLS_W;
  localparam int unsigned DCHK_W  = 9;
  localparam int unsigned TCHK_W  = 4;

  // control register bit positions
  localparam int unsigned CE_BIT       = 0;
  localparam int unsigned UE_BIT       = 1;
  localparam int unsigned RSVD_BIT     = 2;
  localparam int unsigned FAST_BIT     = 3;
  localparam int unsigned FDATA_LSB    = 4;
  localparam int unsigned FDATA_EN_BIT = FDATA_LSB + DCHK_W;
  localparam int unsigned FTAG_LSB     = FDATA_EN_BIT + 1;
  localparam int unsigned FTAG_EN_BIT  = FTAG_LSB + TCHK_W;
  localparam int unsigned CTRL_W       = FTAG_EN_BIT + 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_CACHE_SWC = 3'd0,
    CLS_CACHE_UC  = 3'd1,
    CLS_BUS_UE    = 3'd2,
    CLS_TAG_UE    = 3'd3,
    CLS_BUS_TO    = 3'd4,
    CLS_BUS_BERR  = 3'd5,
    CLS_DATA_CE   = 3'd6,
    CLS_TAG_CE    = 3'd7
  } err_cls_e;

  typedef enum logic [ACC_W-1:0] {
    ACC_FETCH   = 3'd0,
    ACC_LOAD    = 3'd1,
    ACC_ATOMIC  = 3'd2,
    ACC_MERGE   = 3'd3,
    ACC_WBACK   = 3'd4,
    ACC_COPYOUT = 3'd5,
    ACC_VFETCH  = 3'd6,
    ACC_RSVD    = 3'd7
  } acc_e;

  typedef struct packed {
    logic fast;
    logic iacc;
    logic dacc;
    logic disr;
  } trap_req_t;
endpackage

// File: rtl/ecc_trap_cfg.sv
module ecc_trap_cfg
  import ecc_trap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam logic [CTRL_W-1:0] WMASK = ~(CTRL_W'(1) << RSVD_BIT);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i & WMASK;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ecc_trap_route.sv
module ecc_trap_route
  import ecc_trap_pkg::*;
(
  input  logic               valid_i,
  input  logic [CLS_W-1:0]   cls_i,
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [VSUB_W-1:0]  vsub_i,
  input  logic               ce_en_i,
  input  logic               ue_en_i,
  input  logic               fast_en_i,
  output trap_req_t          req_o,
  output logic [NUM_CLS-1:0] log_o
);
  err_cls_e cls;
  acc_e     acc;
  logic     local_rd;
  logic     bg_op;

  assign cls      = err_cls_e'(cls_i);
  assign acc      = acc_e'(acc_i);
  assign local_rd = acc inside {ACC_FETCH, ACC_LOAD, ACC_ATOMIC};
  assign bg_op    = acc inside {ACC_MERGE, ACC_WBACK, ACC_COPYOUT};

  always_comb begin
    req_o = '0;
    if (valid_i) begin
      case (cls)
        CLS_CACHE_SWC, CLS_CACHE_UC: req_o.fast = fast_en_i && local_rd;
        CLS_BUS_UE, CLS_TAG_UE, CLS_BUS_TO, CLS_BUS_BERR: begin
          if (ue_en_i) begin
            case (acc)
              ACC_FETCH:                       req_o.iacc = 1'b1;
              ACC_LOAD, ACC_ATOMIC:            req_o.dacc = 1'b1;
              ACC_MERGE, ACC_WBACK, ACC_COPYOUT: req_o.disr = 1'b1;
              ACC_VFETCH: begin
                case (vsub_i)
                  2'd0:    req_o.iacc = 1'b1;
                  2'd1:    req_o.dacc = 1'b1;
                  2'd2:    req_o.disr = 1'b1;
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
        end
        CLS_DATA_CE, CLS_TAG_CE:
          req_o.disr = ce_en_i && (local_rd || bg_op || acc == ACC_VFETCH);
        default: ;
      endcase
    end
  end

  assign log_o = valid_i ? (NUM_CLS'(1) << cls_i) : '0;
endmodule

// File: rtl/ecc_trap_status.sv
module ecc_trap_status #(
  parameter int unsigned NUM_FLAGS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] status_o
);
  logic [NUM_FLAGS-1:0] status_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/ecc_force_mux.sv
module ecc_force_mux #(
  parameter int unsigned WIDTH = 9
) (
  input  logic             force_i,
  input  logic [WIDTH-1:0] val_i,
  input  logic [WIDTH-1:0] gen_i,
  output logic [WIDTH-1:0] chk_o
);
  assign chk_o = force_i ? val_i : gen_i;
endmodule

// File: rtl/ecc_trap_ctrl.sv
module ecc_trap_ctrl
  import ecc_trap_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        evt_valid_i,
  input  logic [NUM_PORTS*CLS_W-1:0]  evt_cls_i,
  input  logic [NUM_PORTS*ACC_W-1:0]  evt_acc_i,
  input  logic [NUM_PORTS*VSUB_W-1:0] evt_vsub_i,
  input  logic                        csr_we_i,
  input  logic                        csr_addr_i,
  input  logic [DATA_W-1:0]           csr_wdata_i,
  output logic [DATA_W-1:0]           csr_rdata_o,
  input  logic [DCHK_W-1:0]           gen_data_chk_i,
  input  logic [TCHK_W-1:0]           gen_tag_chk_i,
  output logic [DCHK_W-1:0]           data_chk_o,
  output logic [TCHK_W-1:0]           tag_chk_o,
  output logic                        force_data_o,
  output logic                        force_tag_o,
  output logic                        trap_fast_o,
  output logic                        trap_iacc_o,
  output logic                        trap_dacc_o,
  output logic                        trap_disr_o
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_CLS-1:0] status_q;
  logic [NUM_CLS-1:0] set_mask;
  logic [NUM_CLS-1:0] clr_mask;
  logic               fast_en, ue_en, ce_en;
  trap_req_t          port_req [NUM_PORTS];
  logic [NUM_CLS-1:0] port_log [NUM_PORTS];
  trap_req_t          any_req;
  trap_req_t          trap_q;
  logic               unused_wdata;

  assign unused_wdata = ^csr_wdata_i[DATA_W-1:CTRL_W];

  ecc_trap_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (csr_we_i && !csr_addr_i),
    .wdata_i(csr_wdata_i[CTRL_W-1:0]),
    .ctrl_o (ctrl_q)
  );

  assign fast_en = ctrl_q[FAST_BIT];
  assign ue_en   = ctrl_q[UE_BIT];
  assign ce_en   = ctrl_q[CE_BIT];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ecc_trap_route u_route (
      .valid_i  (evt_valid_i[p]),
      .cls_i    (evt_cls_i[p*CLS_W +: CLS_W]),
      .acc_i    (evt_acc_i[p*ACC_W +: ACC_W]),
      .vsub_i   (evt_vsub_i[p*VSUB_W +: VSUB_W]),
      .ce_en_i  (ce_en),
      .ue_en_i  (ue_en),
      .fast_en_i(fast_en),
      .req_o    (port_req[p]),
      .log_o    (port_log[p])
    );
  end

  always_comb begin
    any_req  = '0;
    set_mask = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      any_req  = trap_req_t'(any_req | port_req[p]);
      set_mask = set_mask | port_log[p];
    end
  end

  assign clr_mask = (csr_we_i && csr_addr_i) ? csr_wdata_i[NUM_CLS-1:0] : '0;

  ecc_trap_status #(.NUM_FLAGS(NUM_CLS)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_mask),
    .clr_i   (clr_mask),
    .status_o(status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= '0;
    else         trap_q <= any_req;
  end

  assign trap_fast_o = trap_q.fast;
  assign trap_iacc_o = trap_q.iacc;
  assign trap_dacc_o = trap_q.dacc;
  assign trap_disr_o = trap_q.disr;

  always_comb begin
    if (csr_addr_i) csr_rdata_o = DATA_W'(status_q);
    else            csr_rdata_o = DATA_W'(ctrl_q);
  end

  ecc_force_mux #(.WIDTH(DCHK_W)) u_fdata (
    .force_i(ctrl_q[FDATA_EN_BIT]),
    .val_i  (ctrl_q[FDATA_LSB +: DCHK_W]),
    .gen_i  (gen_data_chk_i),
    .chk_o  (data_chk_o)
  );

  ecc_force_mux #(.WIDTH(TCHK_W)) u_ftag (
    .force_i(ctrl_q[FTAG_EN_BIT]),
    .val_i  (ctrl_q[FTAG_LSB +: TCHK_W]),
    .gen_i  (gen_tag_chk_i),
    .chk_o  (tag_chk_o)
  );

  assign force_data_o = ctrl_q[FDATA_EN_BIT];
  assign force_tag_o  = ctrl_q[FTAG_EN_BIT];
endmodule

// File: rtl/ecc_trap_chk.sv
module ecc_trap_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CTRL_W  = 19,
  parameter int unsigned NUM_CLS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fast_en_i,
  input logic               ue_en_i,
  input logic               ce_en_i,
  input logic [NUM_CLS-1:0] status_i,
  input logic [NUM_CLS-1:0] set_i,
  input logic [NUM_CLS-1:0] clr_i,
  input logic               csr_addr_i,
  input logic [DATA_W-1:0]  csr_rdata_i,
  input logic               trap_fast_i,
  input logic               trap_iacc_i,
  input logic               trap_dacc_i,
  input logic               trap_disr_i
);
  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_addr_i |-> (csr_rdata_i[2] == 1'b0 && (csr_rdata_i >> CTRL_W) == '0));

  p_fast_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_fast_i |-> $past(fast_en_i));

  p_ue_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_iacc_i || trap_dacc_i) |-> $past(ue_en_i));

  p_disr_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_disr_i |-> $past(ce_en_i || ue_en_i));

  p_logged_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(set_i) & ~status_i) == '0);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_i) & ~$past(clr_i)) & ~status_i) == '0);

  p_trap_has_evt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_fast_i || trap_iacc_i || trap_dacc_i || trap_disr_i) |-> $past(set_i != '0));
endmodule

bind ecc_trap_ctrl ecc_trap_chk #(
  .DATA_W (DATA_W),
  .CTRL_W (ecc_trap_pkg::CTRL_W),
  .NUM_CLS(ecc_trap_pkg::NUM_CLS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fast_en_i  (fast_en),
  .ue_en_i    (ue_en),
  .ce_en_i    (ce_en),
  .status_i   (status_q),
  .set_i      (set_mask),
  .clr_i      (clr_mask),
  .csr_addr_i (csr_addr_i),
  .csr_rdata_i(csr_rdata_o),
  .trap_fast_i(trap_fast_o),
  .trap_iacc_i(trap_iacc_o),
  .trap_dacc_i(trap_dacc_o),
  .trap_disr_i(trap_disr_o)
);

// File: tb/ecc_trap_ctrl_tb.sv
module ecc_trap_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NP = 2;
  localparam int DW = 32;
  localparam int NVEC = 29;

  // {enables[3:0], class[2:0], access[2:0], subtype[1:0], expected {fast,iacc,dacc,disr}}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'hB, 3'd0, 3'd0, 2'd0, 4'b1000},
    {4'hB, 3'd1, 3'd1, 2'd0, 4'b1000},
    {4'hB, 3'd0, 3'd2, 2'd0, 4'b1000},
    {4'hB, 3'd1, 3'd3, 2'd0, 4'b0000},
    {4'hB, 3'd0, 3'd4, 2'd0, 4'b0000},
    {4'hB, 3'd1, 3'd5, 2'd0, 4'b0000},
    {4'hB, 3'd2, 3'd0, 2'd0, 4'b0100},
    {4'hB, 3'd3, 3'd1, 2'd0, 4'b0010},
    {4'hB, 3'd4, 3'd2, 2'd0, 4'b0010},
    {4'hB, 3'd5, 3'd3, 2'd0, 4'b0001},
    {4'hB, 3'd2, 3'd4, 2'd0, 4'b0001},
    {4'hB, 3'd4, 3'd5, 2'd0, 4'b0001},
    {4'hB, 3'd5, 3'd6, 2'd0, 4'b0100},
    {4'hB, 3'd2, 3'd6, 2'd1, 4'b0010},
    {4'hB, 3'd3, 3'd6, 2'd2, 4'b0001},
    {4'hB, 3'd4, 3'd6, 2'd3, 4'b0000},
    {4'hB, 3'd6, 3'd1, 2'd0, 4'b0001},
    {4'hB, 3'd7, 3'd3, 2'd0, 4'b0001},
    {4'hB, 3'd6, 3'd6, 2'd0, 4'b0001},
    {4'hB, 3'd6, 3'd7, 2'd0, 4'b0000},
    {4'h0, 3'd0, 3'd0, 2'd0, 4'b0000},
    {4'h0, 3'd2, 3'd0, 2'd0, 4'b0000},
    {4'h0, 3'd6, 3'd1, 2'd0, 4'b0000},
    {4'h8, 3'd2, 3'd0, 2'd0, 4'b0000},
    {4'h8, 3'd0, 3'd1, 2'd0, 4'b1000},
    {4'h2, 3'd0, 3'd0, 2'd0, 4'b0000},
    {4'h2, 3'd5, 3'd1, 2'd0, 4'b0010},
    {4'h2, 3'd7, 3'd4, 2'd0, 4'b0000},
    {4'h1, 3'd6, 3'd5, 2'd0, 4'b0001}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NP-1:0]   evt_valid_i = '0;
  logic [NP*3-1:0] evt_cls_i = '0;
  logic [NP*3-1:0] evt_acc_i = '0;
  logic [NP*2-1:0] evt_vsub_i = '0;
  logic            csr_we_i = 1'b0;
  logic            csr_addr_i = 1'b0;
  logic [DW-1:0]   csr_wdata_i = '0;
  logic [DW-1:0]   csr_rdata_o;
  logic [8:0]      gen_data_chk_i = 9'h0F0;
  logic [3:0]      gen_tag_chk_i = 4'h3;
  logic [8:0]      data_chk_o;
  logic [3:0]      tag_chk_o;
  logic            force_data_o, force_tag_o;
  logic            trap_fast_o, trap_iacc_o, trap_dacc_o, trap_disr_o;
  logic [3:0]      traps;
  int              n_chk = 0;
  int              n_fail = 0;
  bit              done = 1'b0;

  assign traps = {trap_fast_o, trap_iacc_o, trap_dacc_o, trap_disr_o};

  always #2.5 clk = ~clk;

  ecc_trap_ctrl #(.NUM_PORTS(NP), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_valid_i(evt_valid_i), .evt_cls_i(evt_cls_i),
    .evt_acc_i(evt_acc_i), .evt_vsub_i(evt_vsub_i),
    .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .gen_data_chk_i(gen_data_chk_i), .gen_tag_chk_i(gen_tag_chk_i),
    .data_chk_o(data_chk_o), .tag_chk_o(tag_chk_o),
    .force_data_o(force_data_o), .force_tag_o(force_tag_o),
    .trap_fast_o(trap_fast_o), .trap_iacc_o(trap_iacc_o),
    .trap_dacc_o(trap_dacc_o), .trap_disr_o(trap_disr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic addr, input logic [31:0] data);
    csr_we_i = 1'b1; csr_addr_i = addr; csr_wdata_i = data;
    @(negedge clk);
    csr_we_i = 1'b0; csr_wdata_i = '0;
  endtask

  task automatic csr_read(input logic addr, output logic [31:0] data);
    csr_addr_i = addr;
    #1;
    data = csr_rdata_o;
  endtask

  task automatic fire(input logic [1:0] vld, input logic [5:0] cls,
                      input logic [5:0] acc, input logic [3:0] vs);
    evt_valid_i = vld; evt_cls_i = cls; evt_acc_i = acc; evt_vsub_i = vs;
    @(negedge clk);
    evt_valid_i = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset traps", {28'h0, traps}, 32'h0);
    csr_read(1'b0, rd); check("R1 reset ctrl", rd, 32'h0);
    csr_read(1'b1, rd); check("R1 reset status", rd, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reserved bits read zero
    csr_write(1'b0, 32'hFFFF_FFFF);
    csr_read(1'b0, rd); check("R1 ctrl readback mask", rd, 32'h0007_FFFB);

    // R10: force muxes
    csr_write(1'b0, 32'h0006_7A50);
    check("R10 forced data", {23'h0, data_chk_o}, 32'h1A5);
    check("R10 forced tag", {28'h0, tag_chk_o}, 32'h9);
    check("R10 strobes on", {30'h0, force_data_o, force_tag_o}, 32'h3);
    csr_write(1'b0, 32'h0002_5A50);
    check("R10 unforced data", {23'h0, data_chk_o}, 32'h0F0);
    check("R10 unforced tag", {28'h0, tag_chk_o}, 32'h3);
    check("R10 strobes off", {30'h0, force_data_o, force_tag_o}, 32'h0);
    csr_write(1'b0, 32'h0002_7A50);
    check("R10 data only data", {23'h0, data_chk_o}, 32'h1A5);
    check("R10 data only tag", {28'h0, tag_chk_o}, 32'h3);

    // table walk: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NVEC; i++) begin
      csr_write(1'b0, {28'h0, VEC[i][15:12]});
      csr_write(1'b1, 32'hFF);
      fire(2'b01, {3'd0, VEC[i][11:9]}, {3'd0, VEC[i][8:6]}, {2'd0, VEC[i][5:4]});
      check($sformatf("R2/R3/R4/R5/R6/R11 route vec %0d", i), {28'h0, traps},
            {28'h0, VEC[i][3:0]});
      csr_read(1'b1, rd);
      check($sformatf("R7 log vec %0d", i), rd, 32'h1 << VEC[i][11:9]);
    end

    // R9: single-cycle pulse
    csr_write(1'b0, 32'hB);
    fire(2'b01, 6'o00, 6'o00, 4'h0);
    check("R9 pulse high", {28'h0, traps}, 32'h8);
    @(negedge clk);
    check("R9 pulse low", {28'h0, traps}, 32'h0);

    // R9: parallel ports
    fire(2'b11, {3'd7, 3'd2}, {3'd3, 3'd0}, 4'h0);
    check("R9 parallel iacc+disr", {28'h0, traps}, 32'h5);
    fire(2'b11, {3'd3, 3'd0}, {3'd1, 3'd1}, 4'h0);
    check("R9 parallel fast+dacc", {28'h0, traps}, 32'hA);

    // R8: write one to clear
    csr_write(1'b1, 32'hFF);
    fire(2'b11, {3'd5, 3'd2}, {3'd1, 3'd0}, 4'h0);
    csr_read(1'b1, rd); check("R8 two flags", rd, 32'h24);
    csr_write(1'b1, 32'h04);
    csr_read(1'b1, rd); check("R8 w1c one bit", rd, 32'h20);
    csr_write(1'b1, 32'h00);
    csr_read(1'b1, rd); check("R8 write zero no effect", rd, 32'h20);
    // R8: set wins over same-cycle clear
    csr_we_i = 1'b1; csr_addr_i = 1'b1; csr_wdata_i = 32'hFF;
    evt_valid_i = 2'b01; evt_cls_i = {3'd0, 3'd6}; evt_acc_i = {3'd0, 3'd1};
    @(negedge clk);
    csr_we_i = 1'b0; evt_valid_i = '0;
    csr_read(1'b1, rd); check("R8 set beats clear", rd, 32'h40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule